// File: doc/BRIEF.md
# Synchronous DRAM Burst and Latency Engine

This block is the device-side logic of a four-bank synchronous DRAM. All control, address and data inputs are sampled on the rising clock edge. It decodes mode load, row open, row close, read, write and refresh commands. It keeps one open row per bank and holds a mode word taken from the address lines. From that mode word it generates the column sequence of every burst. Read data leaves through a latency line whose depth the mode word selects. A per-cycle mask input blocks write data and turns off the read output enable. The storage is a small behavioural array addressed by bank, open row and column.

A memory controller drives the command pins (chip select, row strobe, column strobe, write enable), a bank select, an address bus and the data input. It receives data on a separate output with an output enable, where an enable of 0 stands for a high-impedance data bus. The mode word sets the burst length (1, 2, 4, 8 or a whole row), sequential or interleaved ordering, a read latency of 2 or 3 clocks, and whether writes burst or always store a single word.

Top module: `sdram_burst_engine`

## Requirements
- R1: During reset and in the first cycle after it, dq_oe is 0. After reset the mode is burst length 1, sequential ordering, read latency 2, and writes follow the burst length.
- R2: With cs_n=0, the pins {ras_n,cas_n,we_n} decode as 000 mode load, 001 refresh, 010 close row, 011 open row, 100 write and 101 read. Every other code, and any code with cs_n=1, is a no-operation. A mode load takes addr[2:0] as length code (000=1, 001=2, 010=4, 011=8, 111=whole row, other codes=1), addr[3] as ordering (1=interleaved), addr[6:4] as latency code (011=3, all others=2) and addr[9] as write mode (1=single). A mode load with addr[8:7] not 00 is ignored, and nothing else changes the mode.
- R3: A read sampled at edge n drives word i on dq_out with dq_oe=1 from edge n+CL-1+i to edge n+CL+i. Before edge n+CL-1, dq_oe remains 0.
- R4: A burst moves L words, where L is the programmed length and a whole row is 2^COL_W words. After the last word, dq_oe returns to 0.
- R5: In sequential order, with start column s, word i uses column s - (s mod L) + ((s + i) mod L).
- R6: In interleaved order, word i uses column s - (s mod L) + ((s mod L) xor i).
- R7: A write sampled at edge n stores dq_in sampled at edge n+i into the column of word i, in the same ordering as a read.
- R8: In single-write mode, a write stores only word 0 at its start column. Reads keep using the programmed burst length.
- R9: While dqm=1 at an edge where a write word is stored, that column keeps its old content.
- R10: dqm=1 sampled at edge m forces dq_oe to 0 from edge m+1 to edge m+2. This is the read word the controller captures at edge m+2.
- R11: A read or write to an open bank accepted during a running burst ends that burst. The new burst's word 0 takes the next slot. Read words already issued still come out.
- R12: Open row takes the row from addr[ROW_W-1:0] for the selected bank. Close row closes the selected bank, or every bank when addr[10]=1. Reads and writes to a closed bank are ignored.
- R13: Refresh changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| bank_sel | input | BANK_W | Bank select for open, close, read and write |
| addr | input | ADDR_W | Row, column, mode word and all-banks flag (bit 10) |
| dqm | input | 1 | Per-cycle data mask |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data |
| dq_oe | output | 1 | Read data enable; 0 means the bus is high impedance |

## Verification
The assertions assume the controller avoids certain overlaps. It never opens a bank that is already open. It never closes a bank whose burst is still running. It never gives a write while read words are still in the latency line. The mask checks also assume dqm is a clean 0 or 1 at every sampled edge. The bench keeps to these rules by closing a bank before reopening it. It also waits for each read burst to drain before issuing the next command, except in the one deliberate read-over-read interruption. The sweeps cover every latency, ordering and length with start columns on and off the block boundaries. Expected columns come from modular arithmetic in the bench, and expected data from a bench-side shadow of each open row.

// File: rtl/sdram_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the synchronous DRAM burst engine.
// Assumes: the command set and the all-banks address bit fixed here.
package sdram_pkg;
    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_MODE,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF
    } cmd_e;

    localparam int ALL_BANKS_BIT = 10;  // close-row address bit selecting every bank
    localparam int CL_MAX        = 3;   // deepest read latency supported
endpackage

// File: rtl/sdram_cmd_decode.sv
`timescale 1ns/1ps
// Command decoder: turns the four command pins into one command value.
// Assumes: pins are stable around the rising edge; unknown codes act as no-operation.
module sdram_cmd_decode
    import sdram_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    // map the strobe pattern to a command while the chip is selected
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MODE;
                3'b001:  cmd = CMD_REF;
                3'b010:  cmd = CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WR;
                3'b101:  cmd = CMD_RD;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdram_mode_reg.sv
`timescale 1ns/1ps
// Mode register: stores burst length, ordering, latency and write mode,
// and derives the column mask and latency select from them.
// Assumes: COL_W >= 3 so an 8-word burst fits inside a row.
module sdram_mode_reg #(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2:0]       len_code,
    input  logic             ilv_in,
    input  logic [2:0]       lat_code,
    input  logic             wr_single_in,
    output logic [COL_W-1:0] len_mask,
    output logic             interleave,
    output logic             cl3,
    output logic             single_wr
);
    logic [2:0] len_q;
    logic [2:0] lat_q;
    logic       ilv_q;
    logic       wrs_q;

    // hold the mode fields; reset gives length 1, sequential, latency 2, burst writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= 3'd0;
            ilv_q <= 1'b0;
            lat_q <= 3'd2;
            wrs_q <= 1'b0;
        end else if (load) begin
            len_q <= len_code;
            ilv_q <= ilv_in;
            lat_q <= lat_code;
            wrs_q <= wr_single_in;
        end
    end

    // turn the length code into a column mask (burst length minus one)
    always_comb begin
        case (len_q)
            3'd1:    len_mask = COL_W'(1);
            3'd2:    len_mask = COL_W'(3);
            3'd3:    len_mask = COL_W'(7);
            3'd7:    len_mask = '1;
            default: len_mask = '0;
        endcase
    end

    assign interleave = ilv_q;
    assign cl3        = (lat_q == 3'd3);
    assign single_wr  = wrs_q;
endmodule

// File: rtl/sdram_burst_seq.sv
`timescale 1ns/1ps
// Burst sequencer: after the first word of a burst, produces the column of
// each later word and carries a tag (bank, direction) for the running burst.
// Assumes: word 0 is served by the caller straight from the command.
module sdram_burst_seq #(
    parameter int COL_W = 4,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] start_mask,
    input  logic             start_ilv,
    input  logic [TAG_W-1:0] tag_in,
    output logic             active,
    output logic [COL_W-1:0] col,
    output logic [TAG_W-1:0] tag
);
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic [COL_W-1:0] cnt_q;
    logic             ilv_q;
    logic             act_q;
    logic [TAG_W-1:0] tag_q;
    logic [COL_W-1:0] offs;

    // capture a new burst, or step the word counter of the running one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            cnt_q  <= '0;
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            tag_q  <= '0;
        end else if (start) begin
            base_q <= start_col;
            mask_q <= start_mask;
            ilv_q  <= start_ilv;
            tag_q  <= tag_in;
            cnt_q  <= COL_W'(1);
            act_q  <= (start_mask != '0);
        end else if (act_q) begin
            cnt_q <= cnt_q + COL_W'(1);
            if (cnt_q == mask_q) begin
                act_q <= 1'b0;
            end
        end
    end

    // wrap the low column bits inside the aligned block of the burst
    always_comb begin
        offs = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
        col  = (base_q & ~mask_q) | (offs & mask_q);
    end

    assign active = act_q;
    assign tag    = tag_q;
endmodule

// File: rtl/sdram_read_pipe.sv
`timescale 1ns/1ps
// Read latency line: delays read words by two or three stages and applies
// the read mask two edges after it is sampled.
// Assumes: a word offered in the cycle before edge n is the one a command at edge n selects.
module sdram_read_pipe
    import sdram_pkg::*;
#(
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_vld,
    input  logic [DQ_W-1:0] word,
    input  logic            mask_in,
    input  logic            cl3,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe
);
    logic [DQ_W-1:0]   data_q [CL_MAX];
    logic [CL_MAX-1:0] vld_q;
    logic              mask_d1;
    logic              mask_d2;

    // shift words and their valid flags down the latency line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int k = 0; k < CL_MAX; k++) begin
                data_q[k] <= '0;
            end
        end else begin
            vld_q[0]  <= word_vld;
            data_q[0] <= word;
            for (int k = 1; k < CL_MAX; k++) begin
                vld_q[k]  <= vld_q[k-1];
                data_q[k] <= data_q[k-1];
            end
        end
    end

    // delay the mask so it lines up with the word it blanks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_d1 <= 1'b0;
            mask_d2 <= 1'b0;
        end else begin
            mask_d1 <= mask_in;
            mask_d2 <= mask_d1;
        end
    end

    assign dq_out = cl3 ? data_q[CL_MAX-1] : data_q[CL_MAX-2];
    assign dq_oe  = (cl3 ? vld_q[CL_MAX-1] : vld_q[CL_MAX-2]) & ~mask_d2;
endmodule

// File: rtl/sdram_burst_engine.sv
`timescale 1ns/1ps
// Synchronous DRAM device engine: command decode, open-row table per bank,
// mode register, burst column sequencing, behavioural array and read latency.
// Assumes: ADDR_W > ALL_BANKS_BIT, COL_W in 3..ADDR_W, ROW_W <= ADDR_W.
module sdram_burst_engine
    import sdram_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 4,
    parameter int ADDR_W = 11,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dqm,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe
);
    localparam int BANKS = 1 << BANK_W;
    localparam int IDX_W = BANK_W + ROW_W + COL_W;
    localparam int WORDS = 1 << IDX_W;
    localparam int TAG_W = BANK_W + 1;

    cmd_e              cmd;
    logic              is_rd_cmd;
    logic              is_wr_cmd;
    logic              new_acc;
    logic              mode_load;
    logic [COL_W-1:0]  bl_mask;
    logic [COL_W-1:0]  eff_mask;
    logic              interleave;
    logic              cl3;
    logic              single_wr;
    logic [BANKS-1:0]  open_q;
    logic [ROW_W-1:0]  row_q [BANKS];
    logic              burst_active;
    logic [COL_W-1:0]  burst_col;
    logic [TAG_W-1:0]  burst_tag;
    logic              cur_vld;
    logic              cur_wr;
    logic [BANK_W-1:0] cur_bank;
    logic [COL_W-1:0]  cur_col;
    logic [IDX_W-1:0]  cur_idx;
    logic [DQ_W-1:0]   mem [WORDS];

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign is_rd_cmd = (cmd == CMD_RD);
    assign is_wr_cmd = (cmd == CMD_WR);
    assign new_acc   = (is_rd_cmd || is_wr_cmd) && open_q[bank_sel];
    assign mode_load = (cmd == CMD_MODE) && (addr[8:7] == 2'b00);
    assign eff_mask  = (is_wr_cmd && single_wr) ? '0 : bl_mask;

    sdram_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (mode_load),
        .len_code     (addr[2:0]),
        .ilv_in       (addr[3]),
        .lat_code     (addr[6:4]),
        .wr_single_in (addr[9]),
        .len_mask     (bl_mask),
        .interleave   (interleave),
        .cl3          (cl3),
        .single_wr    (single_wr)
    );

    // track which banks hold an open row and which row that is
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
            for (int b = 0; b < BANKS; b++) begin
                row_q[b] <= '0;
            end
        end else if (cmd == CMD_ACT) begin
            open_q[bank_sel] <= 1'b1;
            row_q[bank_sel]  <= addr[ROW_W-1:0];
        end else if (cmd == CMD_PRE) begin
            if (addr[ALL_BANKS_BIT]) begin
                open_q <= '0;
            end else begin
                open_q[bank_sel] <= 1'b0;
            end
        end
    end

    sdram_burst_seq #(.COL_W(COL_W), .TAG_W(TAG_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (new_acc),
        .start_col  (addr[COL_W-1:0]),
        .start_mask (eff_mask),
        .start_ilv  (interleave),
        .tag_in     ({bank_sel, is_wr_cmd}),
        .active     (burst_active),
        .col        (burst_col),
        .tag        (burst_tag)
    );

    // pick this cycle's array access: a fresh command wins over a running burst
    always_comb begin
        cur_vld  = new_acc || burst_active;
        cur_wr   = new_acc ? is_wr_cmd : burst_tag[0];
        cur_bank = new_acc ? bank_sel : burst_tag[TAG_W-1:1];
        cur_col  = new_acc ? addr[COL_W-1:0] : burst_col;
        cur_idx  = {cur_bank, row_q[cur_bank], cur_col};
    end

    // store unmasked write words into the behavioural array
    always_ff @(posedge clk) begin
        if (rst_n && cur_vld && cur_wr && !dqm) begin
            mem[cur_idx] <= dq_in;
        end
    end

    sdram_read_pipe #(.DQ_W(DQ_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (cur_vld && !cur_wr),
        .word     (mem[cur_idx]),
        .mask_in  (dqm),
        .cl3      (cl3),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );
endmodule

// File: rtl/sdram_burst_checks.sv
`timescale 1ns/1ps
// Property checker for the burst engine, attached to it by bind.
// Assumes: the legal command usage stated in the brief's verification section.
module sdram_burst_checks
    import sdram_pkg::*;
#(
    parameter int COL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input cmd_e             cmd,
    input logic             dqm,
    input logic             dq_oe,
    input logic             new_acc,
    input logic             is_wr_cmd,
    input logic             single_wr,
    input logic [COL_W-1:0] bl_mask,
    input logic             interleave,
    input logic             cl3,
    input logic             burst_active
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_oe);

    assert_mode_only_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_MODE) |=> $stable({bl_mask, interleave, cl3, single_wr}));

    assert_len_one_no_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (new_acc && (bl_mask == '0)) |=> !burst_active);

    assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (new_acc && is_wr_cmd && single_wr) |=> !burst_active);

    assert_read_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dqm, 2) |-> !dq_oe);
endmodule

bind sdram_burst_engine sdram_burst_checks #(.COL_W(COL_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .dqm          (dqm),
    .dq_oe        (dq_oe),
    .new_acc      (new_acc),
    .is_wr_cmd    (is_wr_cmd),
    .single_wr    (single_wr),
    .bl_mask      (bl_mask),
    .interleave   (interleave),
    .cl3          (cl3),
    .burst_active (burst_active)
);

// File: tb/sim_sdram_burst_engine.sv
`timescale 1ns/1ps
// Bench: sweeps every latency, ordering and length over several start columns,
// then targets write bursts, single writes, masks, interruption, banks and refresh.
module sim_sdram_burst_engine;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_RD  = 4'b0101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  bank_sel = '0;
    logic [10:0] addr = '0;
    logic        dqm = 1'b0;
    logic [3:0]  dq_in = '0;
    logic [3:0]  dq_out;
    logic        dq_oe;

    int total = 0;
    int bad = 0;
    int shadow [4][16];

    always #5 clk = ~clk;

    sdram_burst_engine u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank_sel(bank_sel), .addr(addr), .dqm(dqm),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] c, input int b, input int a, input logic m, input int d);
        {cs_n, ras_n, cas_n, we_n} = c;
        bank_sel = 2'(b);
        addr     = 11'(a);
        dqm      = m;
        dq_in    = 4'(d);
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int blen(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 16;
            default: return 1;
        endcase
    endfunction

    function automatic int ecol(input int s, input int len, input int ilv, input int i);
        int base = s - (s % len);
        if (ilv != 0) return base + ((s % len) ^ i);
        return base + ((s + i) % len);
    endfunction

    task automatic set_mode(input int code, input int ilv, input int cl, input int sw);
        step(C_MRS, 0, code | (ilv << 3) | (cl << 4) | (sw << 9), 1'b0, 0);
    endtask

    // read burst with expected data from the shadow row; mword = masked word or -1
    task automatic rd_burst(input int b, input int s, input int len, input int cl,
                            input int ilv, input int mword, input string req);
        step(C_RD, b, s, (mword >= 0) && (cl - 2 + mword == 0), 0);
        for (int j = 1; j <= cl - 1 + len; j++) begin
            int w;
            step(C_NOP, 0, 0, (mword >= 0) && (j == cl - 2 + mword), 0);
            w = j - (cl - 1);
            if (w < 0) begin
                check("R3 early", int'(dq_oe), 0);
            end else if (w < len) begin
                if (w == mword) begin
                    check("R10 masked", int'(dq_oe), 0);
                end else begin
                    check({req, " oe"}, int'(dq_oe), 1);
                    check({req, " data"}, int'(dq_out), shadow[b][ecol(s, len, ilv, w)]);
                end
            end else begin
                check("R4 end", int'(dq_oe), 0);
            end
        end
    endtask

    // write burst of data (d0 + i); mword = masked word or -1; sw = single-write mode
    task automatic wr_burst(input int b, input int s, input int len, input int ilv,
                            input int mword, input int d0, input int sw);
        step(C_WR, b, s, mword == 0, d0 & 15);
        for (int i = 1; i < len; i++) begin
            step(C_NOP, 0, 0, mword == i, (d0 + i) & 15);
        end
        for (int i = 0; i < ((sw != 0) ? 1 : len); i++) begin
            if (i != mword) shadow[b][ecol(s, len, ilv, i)] = (d0 + i) & 15;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(C_NOP, 0, 0, 1'b0, 0);
        step(C_NOP, 0, 0, 1'b0, 0);
        check("R1 oe in reset", int'(dq_oe), 0);
        rst_n = 1'b1;
        step(C_NOP, 0, 0, 1'b0, 0);
        check("R1 oe after reset", int'(dq_oe), 0);

        // R1: default mode is length 1, latency 2, burst writes
        step(C_ACT, 0, 0, 1'b0, 0);
        step(C_WR, 0, 0, 1'b0, 5);
        shadow[0][0] = 5;
        rd_burst(0, 0, 1, 2, 0, -1, "R1");

        // fill: bank b opens row b, every column gets a distinct pattern
        for (int b = 1; b < 4; b++) step(C_ACT, b, b, 1'b0, 0);
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 16; c++) begin
                shadow[b][c] = (b * 5 + b * 3 + c * 7 + 1) & 15;
                step(C_WR, b, c, 1'b0, shadow[b][c]);
            end
        end

        // R2: deselected pins and reserved bits do not load the mode
        set_mode(0, 0, 2, 0);
        {cs_n, ras_n, cas_n, we_n} = 4'b1000;
        addr = 11'h033;
        @(posedge clk); @(negedge clk);
        step(C_MRS, 0, 11'h0B2, 1'b0, 0);
        rd_burst(3, 5, 1, 2, 0, -1, "R2");
        set_mode(1, 1, 3, 0);
        rd_burst(3, 5, 2, 3, 1, -1, "R2");

        // R3..R6: sweep latency, ordering, length and start column
        for (int cl = 2; cl <= 3; cl++) begin
            for (int ilv = 0; ilv < 2; ilv++) begin
                for (int ci = 0; ci < 5; ci++) begin
                    int code = (ci == 4) ? 7 : ci;
                    set_mode(code, ilv, cl, 0);
                    for (int si = 0; si < 4; si++) begin
                        int s = si * 3 + ((si == 3) ? 4 : 0);
                        rd_burst(s % 4, s, blen(code), cl, ilv, -1, (ilv != 0) ? "R6" : "R5");
                    end
                end
            end
        end

        // R7: sequential and interleaved write bursts, checked column by column
        set_mode(2, 0, 2, 0);
        wr_burst(1, 6, 4, 0, -1, 7, 0);
        set_mode(3, 1, 2, 0);
        wr_burst(2, 5, 8, 1, -1, 1, 0);
        set_mode(0, 0, 2, 0);
        for (int c = 0; c < 16; c++) rd_burst(1, c, 1, 2, 0, -1, "R7");
        for (int c = 0; c < 16; c++) rd_burst(2, c, 1, 2, 0, -1, "R7");

        // R8: single-write mode stores one word, reads still burst
        set_mode(2, 0, 2, 1);
        wr_burst(3, 2, 4, 0, -1, 10, 1);
        rd_burst(3, 0, 4, 2, 0, -1, "R8");

        // R9: masked write word leaves the column unchanged
        set_mode(2, 0, 2, 0);
        wr_burst(0, 8, 4, 0, 1, 3, 0);
        rd_burst(0, 8, 4, 2, 0, -1, "R9");

        // R10: read mask at both latencies
        set_mode(2, 0, 3, 0);
        rd_burst(0, 8, 4, 3, 0, 2, "R10");
        set_mode(2, 0, 2, 0);
        rd_burst(0, 8, 4, 2, 0, 0, "R10");

        // R11: a second read cuts a running 8-word burst
        set_mode(3, 0, 2, 0);
        step(C_RD, 0, 0, 1'b0, 0);
        step(C_NOP, 0, 0, 1'b0, 0);
        check("R11 first word", int'(dq_out), shadow[0][0]);
        step(C_RD, 1, 8, 1'b0, 0);
        check("R11 second word", int'(dq_out), shadow[0][1]);
        for (int j = 3; j <= 11; j++) begin
            step(C_NOP, 0, 0, 1'b0, 0);
            if (j <= 10) begin
                check("R11 new burst oe", int'(dq_oe), 1);
                check("R11 new burst data", int'(dq_out), shadow[1][ecol(8, 8, 0, j - 3)]);
            end else begin
                check("R11 end", int'(dq_oe), 0);
            end
        end

        // R12: closed banks ignore reads and writes; all-banks close; row select
        set_mode(0, 0, 2, 0);
        step(C_PRE, 2, 0, 1'b0, 0);
        step(C_RD, 2, 1, 1'b0, 0);
        for (int j = 1; j <= 3; j++) begin
            step(C_NOP, 0, 0, 1'b0, 0);
            check("R12 closed read", int'(dq_oe), 0);
        end
        step(C_WR, 2, 1, 1'b0, 15 - shadow[2][1]);
        step(C_PRE, 0, 1 << 10, 1'b0, 0);
        step(C_RD, 1, 3, 1'b0, 0);
        for (int j = 1; j <= 3; j++) begin
            step(C_NOP, 0, 0, 1'b0, 0);
            check("R12 all closed read", int'(dq_oe), 0);
        end
        for (int b = 0; b < 4; b++) step(C_ACT, b, b, 1'b0, 0);
        rd_burst(2, 1, 1, 2, 0, -1, "R12");
        step(C_PRE, 0, 0, 1'b0, 0);
        step(C_ACT, 0, 1, 1'b0, 0);
        step(C_WR, 0, 4, 1'b0, (shadow[0][4] + 5) & 15);
        step(C_RD, 0, 4, 1'b0, 0);
        step(C_NOP, 0, 0, 1'b0, 0);
        check("R12 other row", int'(dq_out), (shadow[0][4] + 5) & 15);
        step(C_NOP, 0, 0, 1'b0, 0);
        step(C_PRE, 0, 0, 1'b0, 0);
        step(C_ACT, 0, 0, 1'b0, 0);
        rd_burst(0, 4, 1, 2, 0, -1, "R12");

        // R13: refresh keeps contents
        step(C_REF, 0, 0, 1'b0, 0);
        step(C_REF, 0, 0, 1'b0, 0);
        rd_burst(1, 3, 1, 2, 0, -1, "R13");
        rd_burst(2, 5, 1, 2, 0, -1, "R13");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule